// File: doc/BRIEF.md
# Stereo PCM Payload Formatter

This block sits between an audio sample FIFO and a serial consumer-audio transmitter. It turns each stereo sample pair into one left and one right 24-bit subframe payload. Samples arrive on a valid/ready interface. A frame-time pulse from the transmitter decides when a pair is taken. The formatting controls are static inputs that firmware sets while the stream is stopped.

Each channel is formatted on its own. In narrow mode, the low 16 bits of the sample are placed right, centered or left inside the 24-bit word. Options can flip the sample's top bit, or copy it into the unused upper bits. A routing code can exchange the channels or duplicate one channel onto both. Each output channel can be muted to one of seven constants. When the FIFO has nothing at frame time, the block flags an underrun and sends a fill value: zero, the mute constant, or a replay of the last real pair. A hold input freezes the output side.

Top module: `pcm_payload_formatter`

## Requirements
- R1: When `frame_tick` is high, `cfg_hold` is low and the block is out of reset, `smp_ready` is high in that same cycle, and a pair with `smp_valid` high is consumed. The result shows on the next cycle: `out_strobe` is high for one cycle and `out_left`/`out_right` carry the new payloads.
- R2: With `cfg_narrow`=0 the payload is the full 24-bit sample. `cfg_msb_invert`=1 flips bit 23. `cfg_msb_extend` has no effect in this mode.
- R3: With `cfg_narrow`=1 only sample bits [15:0] are used, and `cfg_align` places them. Code 0 gives bits [15:0] with 8 upper bits zero. Code 1 gives bits [19:4] with 4 zero bits above and 4 below. Code 2 gives bits [23:8] with 8 zero bits below. Code 3 behaves like code 0.
- R4: In narrow mode, `cfg_msb_invert`=1 flips sample bit 15 before placement.
- R5: In narrow mode, `cfg_msb_extend`=1 copies the sample's top bit (after any inversion) into every payload bit above the placed sample. Bits below the sample stay zero. Left placement has no bits above the sample.
- R6: `cfg_swap` routes the formatted channels. Code 0 passes them straight through. Code 1 exchanges left and right. Code 2 sends left to both outputs. Code 3 sends right to both outputs.
- R7: `cfg_mute_code` selects the mute constant: 0 gives 0x000000, 1 gives 0x800000, 2 gives 0x080000, 3 gives 0x008000, 4 gives 0x000001, 5 gives 0x000010, 6 gives 0x000100, and 7 gives 0x000000. `cfg_mute_l` and `cfg_mute_r` each replace the routed payload of their own output channel with this constant.
- R8: Mute takes priority over both the live sample and the underrun fill.
- R9: A frame tick with `smp_valid` low consumes nothing. The block still raises `out_strobe` on the next cycle, and `underrun` is high in that same cycle. `cfg_fill` selects the payload: 0 or 3 gives zero, 1 gives the mute constant, and 2 gives the stored last pair.
- R10: The stored last pair is the routed, unmuted payload of the most recent consumed sample pair. Fill frames and mute never change it, and it is zero after reset.
- R11: While `cfg_hold` is high, frame ticks are ignored. `smp_ready` stays low, no strobe is produced, and `out_left`/`out_right` keep their values.
- R12: After reset, `out_strobe` and `underrun` are low and both payload outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | Frame-time request from the transmitter |
| smp_valid | input | 1 | A sample pair is offered |
| smp_ready | output | 1 | The offered pair is taken this cycle |
| smp_left | input | 24 | Left sample |
| smp_right | input | 24 | Right sample |
| cfg_narrow | input | 1 | 1 selects 16-bit samples |
| cfg_align | input | 2 | 16-bit placement code |
| cfg_msb_invert | input | 1 | Flip the sample top bit |
| cfg_msb_extend | input | 1 | Copy the top bit into unused upper bits |
| cfg_swap | input | 2 | Channel routing code |
| cfg_hold | input | 1 | Freeze the output side |
| cfg_mute_l | input | 1 | Mute left output |
| cfg_mute_r | input | 1 | Mute right output |
| cfg_mute_code | input | 3 | Mute constant select |
| cfg_fill | input | 2 | Underrun fill policy |
| out_strobe | output | 1 | New payload pair, one cycle |
| out_left | output | 24 | Left payload |
| out_right | output | 24 | Right payload |
| underrun | output | 1 | The strobed frame is a fill frame |

## Verification
`smp_ready` answers in the same cycle as the tick. The strobe, the payloads and the underrun flag all appear one cycle after the tick cycle, once the next rising edge has passed. The bench drives each tick on a falling edge and checks `smp_ready` one nanosecond later. At that moment it queues the expected frame, computed from its own model of formatting, routing, mute and the stored last pair. The monitor compares each strobe against the head of the queue on the following falling edge, so any missing, extra or late strobe is reported. After a held tick, the bench checks one edge later that no strobe appeared and that the payloads are unchanged.

// File: rtl/pcm_fmt_pkg.sv
package pcm_fmt_pkg;
  typedef enum logic [1:0] {
    ALIGN_RIGHT  = 2'd0,
    ALIGN_CENTER = 2'd1,
    ALIGN_LEFT   = 2'd2,
    ALIGN_RSVD   = 2'd3
  } align_e;

  typedef enum logic [1:0] {
    ROUTE_STRAIGHT = 2'd0,
    ROUTE_CROSS    = 2'd1,
    ROUTE_DUP_L    = 2'd2,
    ROUTE_DUP_R    = 2'd3
  } route_e;

  typedef enum logic [1:0] {
    FILL_ZERO   = 2'd0,
    FILL_CONST  = 2'd1,
    FILL_REPLAY = 2'd2,
    FILL_RSVD   = 2'd3
  } fill_e;
endpackage

// File: rtl/pcm_lane_format.sv
module pcm_lane_format
  import pcm_fmt_pkg::*;
#(
  parameter int unsigned W = 24,
  parameter int unsigned N = 16
) (
  input  logic [W-1:0] sample,
  input  logic         narrow,
  input  align_e       align,
  input  logic         invert,
  input  logic         extend,
  output logic [W-1:0] payload
);
  localparam int unsigned PAD   = W - N;
  localparam int unsigned HALF  = PAD / 2;
  localparam int unsigned UPPER = PAD - HALF;

  logic [N-1:0] narrow_s;
  logic         ext_bit;
  logic [W-1:0] wide_s;
  logic [W-1:0] placed;

  always_comb begin
    narrow_s        = sample[N-1:0];
    narrow_s[N-1]   = narrow_s[N-1] ^ invert;
    ext_bit         = extend & narrow_s[N-1];
    wide_s          = sample;
    wide_s[W-1]     = wide_s[W-1] ^ invert;
    case (align)
      ALIGN_CENTER: placed = {{UPPER{ext_bit}}, narrow_s, {HALF{1'b0}}};
      ALIGN_LEFT:   placed = {narrow_s, {PAD{1'b0}}};
      default:      placed = {{PAD{ext_bit}}, narrow_s};
    endcase
    payload = narrow ? placed : wide_s;
  end
endmodule

// File: rtl/pcm_mute_table.sv
module pcm_mute_table #(
  parameter int unsigned W = 24
) (
  input  logic [2:0]   code,
  output logic [W-1:0] value
);
  always_comb begin
    value = '0;
    case (code)
      3'd1: value[W-1] = 1'b1;
      3'd2: value[W-5] = 1'b1;
      3'd3: value[W-9] = 1'b1;
      3'd4: value[0]   = 1'b1;
      3'd5: value[4]   = 1'b1;
      3'd6: value[8]   = 1'b1;
      default: value = '0;
    endcase
  end
endmodule

// File: rtl/pcm_frame_route.sv
module pcm_frame_route
  import pcm_fmt_pkg::*;
#(
  parameter int unsigned W = 24
) (
  input  logic [W-1:0] live_l,
  input  logic [W-1:0] live_r,
  input  logic [W-1:0] last_l,
  input  logic [W-1:0] last_r,
  input  logic [W-1:0] mute_val,
  input  route_e       route,
  input  fill_e        fill,
  input  logic         have_pair,
  input  logic         mute_l,
  input  logic         mute_r,
  output logic [W-1:0] routed_l,
  output logic [W-1:0] routed_r,
  output logic [W-1:0] final_l,
  output logic [W-1:0] final_r
);
  logic [W-1:0] fill_l, fill_r, pre_l, pre_r;

  always_comb begin
    case (route)
      ROUTE_CROSS: begin routed_l = live_r; routed_r = live_l; end
      ROUTE_DUP_L: begin routed_l = live_l; routed_r = live_l; end
      ROUTE_DUP_R: begin routed_l = live_r; routed_r = live_r; end
      default:     begin routed_l = live_l; routed_r = live_r; end
    endcase
  end

  always_comb begin
    case (fill)
      FILL_CONST:  begin fill_l = mute_val; fill_r = mute_val; end
      FILL_REPLAY: begin fill_l = last_l;   fill_r = last_r;   end
      default:     begin fill_l = '0;       fill_r = '0;       end
    endcase
    pre_l   = have_pair ? routed_l : fill_l;
    pre_r   = have_pair ? routed_r : fill_r;
    final_l = mute_l ? mute_val : pre_l;
    final_r = mute_r ? mute_val : pre_r;
  end
endmodule

// File: rtl/pcm_payload_formatter.sv
module pcm_payload_formatter
  import pcm_fmt_pkg::*;
#(
  parameter int unsigned PAYLOAD_W = 24,
  parameter int unsigned NARROW_W  = 16,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_tick,
  input  logic                 smp_valid,
  output logic                 smp_ready,
  input  logic [PAYLOAD_W-1:0] smp_left,
  input  logic [PAYLOAD_W-1:0] smp_right,
  input  logic                 cfg_narrow,
  input  logic [1:0]           cfg_align,
  input  logic                 cfg_msb_invert,
  input  logic                 cfg_msb_extend,
  input  logic [1:0]           cfg_swap,
  input  logic                 cfg_hold,
  input  logic                 cfg_mute_l,
  input  logic                 cfg_mute_r,
  input  logic [2:0]           cfg_mute_code,
  input  logic [1:0]           cfg_fill,
  output logic                 out_strobe,
  output logic [PAYLOAD_W-1:0] out_left,
  output logic [PAYLOAD_W-1:0] out_right,
  output logic                 underrun
);
  localparam int unsigned LANES = 2;

  // reset release synchronizer
  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign run = rst_pipe_q[RST_STAGES-1];

  // per-lane formatting
  logic [PAYLOAD_W-1:0] lane_in  [LANES];
  logic [PAYLOAD_W-1:0] lane_out [LANES];

  assign lane_in[0] = smp_left;
  assign lane_in[1] = smp_right;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pcm_lane_format #(.W(PAYLOAD_W), .N(NARROW_W)) u_fmt (
      .sample  (lane_in[g]),
      .narrow  (cfg_narrow),
      .align   (align_e'(cfg_align)),
      .invert  (cfg_msb_invert),
      .extend  (cfg_msb_extend),
      .payload (lane_out[g])
    );
  end

  logic [PAYLOAD_W-1:0] mute_val;
  pcm_mute_table #(.W(PAYLOAD_W)) u_mute (
    .code  (cfg_mute_code),
    .value (mute_val)
  );

  // state
  logic                 strobe_q, strobe_d;
  logic                 under_q, under_d;
  logic [PAYLOAD_W-1:0] out_l_q, out_r_q;
  logic [PAYLOAD_W-1:0] last_l_q, last_r_q;
  logic [PAYLOAD_W-1:0] routed_l, routed_r, final_l, final_r;
  logic                 fire, pop;

  pcm_frame_route #(.W(PAYLOAD_W)) u_route (
    .live_l    (lane_out[0]),
    .live_r    (lane_out[1]),
    .last_l    (last_l_q),
    .last_r    (last_r_q),
    .mute_val  (mute_val),
    .route     (route_e'(cfg_swap)),
    .fill      (fill_e'(cfg_fill)),
    .have_pair (smp_valid),
    .mute_l    (cfg_mute_l),
    .mute_r    (cfg_mute_r),
    .routed_l  (routed_l),
    .routed_r  (routed_r),
    .final_l   (final_l),
    .final_r   (final_r)
  );

  always_comb begin
    fire     = frame_tick & ~cfg_hold & run;
    pop      = fire & smp_valid;
    strobe_d = fire;
    under_d  = fire & ~smp_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      under_q  <= 1'b0;
    end else begin
      strobe_q <= strobe_d;
      under_q  <= under_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_l_q <= '0;
      out_r_q <= '0;
    end else if (fire) begin
      out_l_q <= final_l;
      out_r_q <= final_r;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_l_q <= '0;
      last_r_q <= '0;
    end else if (pop) begin
      last_l_q <= routed_l;
      last_r_q <= routed_r;
    end
  end

  assign smp_ready  = fire;
  assign out_strobe = strobe_q;
  assign underrun   = under_q;
  assign out_left   = out_l_q;
  assign out_right  = out_r_q;
endmodule

// File: rtl/pcm_formatter_chk.sv
module pcm_formatter_chk #(
  parameter int unsigned W = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic         frame_tick,
  input logic         smp_valid,
  input logic         cfg_hold,
  input logic         cfg_mute_l,
  input logic [2:0]   cfg_mute_code,
  input logic [1:0]   cfg_fill,
  input logic         out_strobe,
  input logic [W-1:0] out_left,
  input logic [W-1:0] out_right,
  input logic         underrun
);
  function automatic logic [W-1:0] exp_mute(input logic [2:0] c);
    logic [W-1:0] v;
    v = '0;
    case (c)
      3'd1: v = {1'b1, {(W-1){1'b0}}};
      3'd2: v = {4'b0000, 1'b1, {(W-5){1'b0}}};
      3'd3: v = {8'h00, 1'b1, {(W-9){1'b0}}};
      3'd4: v = {{(W-1){1'b0}}, 1'b1};
      3'd5: v = {{(W-5){1'b0}}, 5'b10000};
      3'd6: v = {{(W-9){1'b0}}, 9'b100000000};
      default: v = '0;
    endcase
    return v;
  endfunction

  // R1: a strobe only follows an accepted tick
  a_r1_strobe_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
    out_strobe |-> $past(frame_tick && !cfg_hold));

  // R9: underrun is only flagged on a strobed frame
  a_r9_underrun_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> out_strobe);

  // R9: flag reflects the availability of a pair at tick time
  a_r9_underrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
    out_strobe |-> (underrun == !$past(smp_valid)));

  // R11: hold freezes the output side
  a_r11_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_hold) |-> (!out_strobe && $stable(out_left) && $stable(out_right)));

  // R7: a muted left channel carries the selected constant
  a_r7_mute_left_const: assert property (@(posedge clk) disable iff (!rst_n)
    (out_strobe && $past(cfg_mute_l)) |-> (out_left == exp_mute($past(cfg_mute_code))));

  // R9: zero fill on an unmuted left channel
  a_r9_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (out_strobe && underrun && ($past(cfg_fill) == 2'd0) && !$past(cfg_mute_l))
      |-> (out_left == '0));
endmodule

bind pcm_payload_formatter pcm_formatter_chk #(.W(PAYLOAD_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .frame_tick    (frame_tick),
  .smp_valid     (smp_valid),
  .cfg_hold      (cfg_hold),
  .cfg_mute_l    (cfg_mute_l),
  .cfg_mute_code (cfg_mute_code),
  .cfg_fill      (cfg_fill),
  .out_strobe    (out_strobe),
  .out_left      (out_left),
  .out_right     (out_right),
  .underrun      (underrun)
);

// File: tb/tb_pcm_payload_formatter.sv
`timescale 1ns/1ps
module tb_pcm_payload_formatter;
  logic        clk, rst_n;
  logic        frame_tick, smp_valid, smp_ready;
  logic [23:0] smp_left, smp_right;
  logic        cfg_narrow, cfg_msb_invert, cfg_msb_extend, cfg_hold;
  logic        cfg_mute_l, cfg_mute_r;
  logic [1:0]  cfg_align, cfg_swap, cfg_fill;
  logic [2:0]  cfg_mute_code;
  logic        out_strobe, underrun;
  logic [23:0] out_left, out_right;

  pcm_payload_formatter dut (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_left(smp_left), .smp_right(smp_right),
    .cfg_narrow(cfg_narrow), .cfg_align(cfg_align), .cfg_msb_invert(cfg_msb_invert),
    .cfg_msb_extend(cfg_msb_extend), .cfg_swap(cfg_swap), .cfg_hold(cfg_hold),
    .cfg_mute_l(cfg_mute_l), .cfg_mute_r(cfg_mute_r), .cfg_mute_code(cfg_mute_code),
    .cfg_fill(cfg_fill), .out_strobe(out_strobe), .out_left(out_left),
    .out_right(out_right), .underrun(underrun)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    logic [23:0] l;
    logic [23:0] r;
    logic        und;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          n_cmp = 0;
  int          n_bad = 0;
  logic        mon_on = 1'b0;
  logic [23:0] m_last_l = '0, m_last_r = '0;
  logic [23:0] m_out_l = '0, m_out_r = '0;

  task automatic chk(input logic ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] fmt(input logic [23:0] s);
    logic [31:0] v;
    int sh;
    if (!cfg_narrow) begin
      v = {8'h0, s};
      if (cfg_msb_invert) v = v ^ 32'h0080_0000;
      return v[23:0];
    end
    v = {16'h0, s[15:0]};
    if (cfg_msb_invert) v = v ^ 32'h0000_8000;
    sh = (cfg_align == 2'd1) ? 4 : (cfg_align == 2'd2) ? 8 : 0;
    if (cfg_msb_extend && v[15]) v = (v << sh) | (32'hFFFF_FFFF << (16 + sh));
    else v = v << sh;
    return v[23:0];
  endfunction

  function automatic logic [23:0] mconst(input logic [2:0] c);
    case (c)
      3'd1: return 24'h800000;
      3'd2: return 24'h080000;
      3'd3: return 24'h008000;
      3'd4: return 24'h000001;
      3'd5: return 24'h000010;
      3'd6: return 24'h000100;
      default: return 24'h000000;
    endcase
  endfunction

  // driver: one frame tick, expected result queued
  task automatic frame(input logic v, input logic [23:0] l, input logic [23:0] r, input string tag);
    exp_t e;
    logic [23:0] fl, fr, rl, rr, pl, pr;
    smp_valid  = v;
    smp_left   = l;
    smp_right  = r;
    frame_tick = 1'b1;
    #1;
    chk(smp_ready == !cfg_hold, cfg_hold ? "R11 ready" : "R1 ready",
        {47'h0, smp_ready}, {47'h0, !cfg_hold});
    if (!cfg_hold) begin
      fl = fmt(l); fr = fmt(r);
      case (cfg_swap)
        2'd1: begin rl = fr; rr = fl; end
        2'd2: begin rl = fl; rr = fl; end
        2'd3: begin rl = fr; rr = fr; end
        default: begin rl = fl; rr = fr; end
      endcase
      if (v) begin
        pl = rl; pr = rr;
        m_last_l = rl; m_last_r = rr;
      end else if (cfg_fill == 2'd1) begin
        pl = mconst(cfg_mute_code); pr = pl;
      end else if (cfg_fill == 2'd2) begin
        pl = m_last_l; pr = m_last_r;
      end else begin
        pl = '0; pr = '0;
      end
      if (cfg_mute_l) pl = mconst(cfg_mute_code);
      if (cfg_mute_r) pr = mconst(cfg_mute_code);
      e.l = pl; e.r = pr; e.und = !v; e.tag = tag;
      m_out_l = pl; m_out_r = pr;
      sb.push_back(e);
    end
    @(negedge clk);
    frame_tick = 1'b0;
    smp_valid  = 1'b0;
    @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (mon_on && out_strobe) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R1 unexpected strobe", {out_left, out_right}, 48'h0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk({out_left, out_right} == {e.l, e.r}, e.tag, {out_left, out_right}, {e.l, e.r});
        chk(underrun == e.und, {e.tag, " R9 flag"}, {47'h0, underrun}, {47'h0, e.und});
      end
    end
  end

  task automatic cfg_default();
    cfg_narrow = 0; cfg_align = 0; cfg_msb_invert = 0; cfg_msb_extend = 0;
    cfg_swap = 0; cfg_hold = 0; cfg_mute_l = 0; cfg_mute_r = 0;
    cfg_mute_code = 0; cfg_fill = 0;
  endtask

  logic done = 1'b0;

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; frame_tick = 0; smp_valid = 0; smp_left = '0; smp_right = '0;
    cfg_default();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R12 reset state
    chk(out_strobe == 0 && underrun == 0, "R12 flags", {46'h0, out_strobe, underrun}, 48'h0);
    chk({out_left, out_right} == 48'h0, "R12 payload", {out_left, out_right}, 48'h0);
    mon_on = 1'b1;

    // R10 replay straight after reset gives zero
    cfg_fill = 2'd2;
    frame(1'b0, 24'h0, 24'h0, "R10 reset replay");
    cfg_fill = 2'd0;

    // R1/R2 full-width samples
    frame(1'b1, 24'h123456, 24'hABCDEF, "R1 wide pass");
    frame(1'b1, 24'hFEDCBA, 24'h000001, "R2 wide pass");
    cfg_msb_invert = 1; cfg_msb_extend = 1;
    frame(1'b1, 24'h7FFFFF, 24'h800000, "R2 wide invert");
    cfg_msb_invert = 0; cfg_msb_extend = 0;

    // R3 placement codes
    cfg_narrow = 1;
    for (int a = 0; a < 4; a++) begin
      cfg_align = 2'(a);
      frame(1'b1, 24'hFF8ABC, 24'h001234, "R3 align");
    end
    // R4/R5 invert and extend across placements
    for (int a = 0; a < 3; a++) begin
      cfg_align = 2'(a);
      cfg_msb_extend = 1;
      frame(1'b1, 24'h008001, 24'h007FFF, "R5 extend");
      cfg_msb_invert = 1;
      frame(1'b1, 24'h008001, 24'h007FFF, "R4 invert+extend");
      cfg_msb_extend = 0;
      frame(1'b1, 24'h00C3A5, 24'h0012F0, "R4 invert");
      cfg_msb_invert = 0;
    end
    cfg_narrow = 0; cfg_align = 0;

    // R6 routing
    for (int s = 0; s < 4; s++) begin
      cfg_swap = 2'(s);
      frame(1'b1, 24'h111111, 24'h222222, "R6 swap");
    end
    cfg_swap = 0;

    // R7 mute constants on each side
    for (int c = 0; c < 8; c++) begin
      cfg_mute_code = 3'(c);
      cfg_mute_l = 1; cfg_mute_r = 0;
      frame(1'b1, 24'h5A5A5A, 24'hA5A5A5, "R7 mute left");
      cfg_mute_l = 0; cfg_mute_r = 1;
      frame(1'b1, 24'h5A5A5A, 24'hA5A5A5, "R7 mute right");
    end
    cfg_mute_r = 0;

    // R9/R10 fill policies and last-pair storage
    cfg_mute_code = 3'd2; cfg_swap = 2'd1;
    frame(1'b1, 24'h0A0B0C, 24'h0D0E0F, "R10 load last");
    cfg_swap = 2'd0;
    cfg_fill = 2'd2;
    frame(1'b0, 24'hFFFFFF, 24'hFFFFFF, "R9 replay");
    cfg_mute_l = 1;
    frame(1'b1, 24'h314159, 24'h265358, "R10 muted pop");
    cfg_mute_l = 0;
    frame(1'b0, 24'h0, 24'h0, "R10 replay after mute");
    cfg_fill = 2'd1;
    frame(1'b0, 24'h0, 24'h0, "R9 const fill");
    cfg_fill = 2'd2;
    frame(1'b0, 24'h0, 24'h0, "R10 replay after fill");
    cfg_fill = 2'd0;
    frame(1'b0, 24'h0, 24'h0, "R9 zero fill");
    cfg_fill = 2'd3;
    frame(1'b0, 24'h0, 24'h0, "R9 reserved fill");

    // R8 mute over fill
    cfg_fill = 2'd2; cfg_mute_code = 3'd6; cfg_mute_r = 1;
    frame(1'b0, 24'h0, 24'h0, "R8 mute over replay");
    cfg_mute_l = 1; cfg_mute_r = 0; cfg_fill = 2'd0; cfg_mute_code = 3'd1;
    frame(1'b0, 24'h0, 24'h0, "R8 mute over zero");
    cfg_default();

    // R11 hold
    frame(1'b1, 24'h777777, 24'h888888, "R11 before hold");
    cfg_hold = 1;
    frame(1'b1, 24'h999999, 24'hAAAAAA, "R11 held");
    frame(1'b0, 24'h0, 24'h0, "R11 held underrun");
    chk({out_left, out_right} == {m_out_l, m_out_r}, "R11 payload kept",
        {out_left, out_right}, {m_out_l, m_out_r});
    cfg_hold = 0;
    frame(1'b1, 24'h999999, 24'hAAAAAA, "R11 after hold");

    repeat (3) @(negedge clk);
    chk(sb.size() == 0, "R1 all strobes seen", 48'(sb.size()), 48'h0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule